// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block sends a message, one byte at a time, over the monitor slot of a frame-based serial control channel. In each frame it places a data byte and an active-low valid flag (tx_mx) in that frame's slot. The far end answers with an active-low acknowledge flag (rx_mr). A frame multiplexer outside the block raises `frame_stb` once per frame, nominally every 125 µs. The block samples `rx_mr` and updates its slot outputs only on that strobe, so each byte stays in the slot for as many frames as the handshake needs.

A host loads a byte into the data register and then sets the enable bit. The byte is flagged valid until the far end acknowledges it. Each acknowledgement releases the flag for at least one frame and raises a level interrupt. The host may then load the next byte. To end the message, the host clears the enable bit. The block then drives the flag high for good, fills the slot with the idle value and drops its busy status once the far end has released its acknowledge. Framing of the full serial frame, clock recovery and arbitration between several transmitters are handled elsewhere.

Top module: `mon_tx_ctrl`

## Requirements
- R1: After reset, tx_mx is 1, tx_byte is 0xFF, irq is 0 and the status register (address 2) reads 0.
- R2: While the busy status bit is 0, the slot carries 0xFF and tx_mx stays 1 on every frame, even when data has been written but enable (address 1, bit 0) is 0.
- R3: tx_mx goes low only at a frame strobe that finds both enable set and a byte written to the data register (address 0) since the last byte was taken. The next frame's tx_byte equals the written value.
- R4: The busy status bit (address 2, bit 0) becomes 1 in the frame where tx_mx first goes low, and stays 1 until the end-of-message sequence completes.
- R5: While rx_mr is 1, the byte and tx_mx = 0 are held unchanged across frames, and they change only at a frame strobe. A data register write during this time does not alter tx_byte.
- R6: A frame strobe that samples rx_mr = 0 while a byte is flagged sets tx_mx to 1 for the next frame and sets irq and the pending bit (address 2, bit 1).
- R7: After an acknowledgement, tx_mx stays 1 for at least GAP_FRAMES frames with the previous byte still in the slot. A new byte is flagged only at a strobe that finds rx_mr = 1 and new data written.
- R8: irq is a level that stays 1 until the status register is read. That read returns the pending bit as 1 and clears irq after the read cycle.
- R9: If enable is 0 at a strobe after an acknowledgement, the slot goes to 0xFF and tx_mx to 1, and busy stays 1. Busy drops to 0 at the first later strobe that samples rx_mr = 1.
- R10: The data register reads back its last written value, the control register returns enable in bit 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse per frame; the handshake advances on it |
| rx_mr | input | 1 | Far end acknowledge, active low |
| tx_byte | output | DATA_W | Data byte for the current frame's slot |
| tx_mx | output | 1 | Byte-valid flag, active low |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (a read of status clears irq) |
| reg_addr | input | ADDR_W | Host register address |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Host read data, valid in the cycle of reg_rd |
| irq | output | 1 | Acknowledge interrupt, level, cleared on status read |

## Verification
The handshake is driven with several `rx_mr` patterns: held high for several frames, dropped for a single frame, and held low across the gap. The first shows that the byte is held. The second shows the release and the interrupt. The third shows that a pending byte is not flagged while the far end still acknowledges. A data write without enable and a data write during a flagged byte show that neither reaches the slot. An end-of-message run with `rx_mr` still low, then high, separates the moment the slot goes idle from the moment busy drops.

// File: rtl/mon_tx_pkg.sv
`timescale 1ns/1ps
package mon_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_GAP  = 2'd2,
      ST_END  = 2'd3
   } mtx_state_t;

   localparam int unsigned RA_DATA = 0;
   localparam int unsigned RA_CTRL = 1;
   localparam int unsigned RA_STAT = 2;
   localparam int unsigned STAT_BUSY_BIT = 0;
   localparam int unsigned STAT_PEND_BIT = 1;
endpackage

// File: rtl/mon_tx_regs.sv
`timescale 1ns/1ps
module mon_tx_regs
   import mon_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              take,
   input  logic              ack,
   input  logic              busy,
   output logic [DATA_W-1:0] data_q,
   output logic              data_new,
   output logic              en_q,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(RA_DATA);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RA_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RA_STAT);

   logic wr_data, wr_ctrl, rd_stat;
   assign wr_data = wr && (addr == A_DATA);
   assign wr_ctrl = wr && (addr == A_CTRL);
   assign rd_stat = rd && (addr == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         data_new <= 1'b0;
         en_q     <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (wr_data) data_q <= wdata;
         if (wr_data)   data_new <= 1'b1;
         else if (take) data_new <= 1'b0;
         if (wr_ctrl) en_q <= wdata[0];
         if (ack)          irq <= 1'b1;
         else if (rd_stat) irq <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (addr)
            A_DATA: rdata = data_q;
            A_CTRL: rdata[0] = en_q;
            A_STAT: begin
               rdata[STAT_BUSY_BIT] = busy;
               rdata[STAT_PEND_BIT] = irq;
            end
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/mon_tx_fsm.sv
`timescale 1ns/1ps
module mon_tx_fsm
   import mon_tx_pkg::*;
#(
   parameter int unsigned GAP_FRAMES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_stb,
   input  logic       rx_mr,
   input  logic       en,
   input  logic       data_new,
   output mtx_state_t state,
   output logic       take,
   output logic       ack
);
   localparam int unsigned CNT_W = (GAP_FRAMES > 1) ? $clog2(GAP_FRAMES) : 1;

   mtx_state_t state_q, state_d;
   logic       gap_done;

   generate
      if (GAP_FRAMES < 1) begin : g_bad_gap
         $error("GAP_FRAMES must be at least 1");
      end
      if (GAP_FRAMES == 1) begin : g_gap_single
         assign gap_done = 1'b1;
      end else begin : g_gap_count
         logic [CNT_W-1:0] gap_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  gap_cnt <= '0;
            else if (state_q != ST_GAP)  gap_cnt <= '0;
            else if (frame_stb && !gap_done) gap_cnt <= gap_cnt + 1'b1;
         end
         assign gap_done = (gap_cnt == CNT_W'(GAP_FRAMES - 1));
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      take    = 1'b0;
      ack     = 1'b0;
      if (frame_stb) begin
         unique case (state_q)
            ST_IDLE: if (en && data_new) begin
               state_d = ST_SEND;
               take    = 1'b1;
            end
            ST_SEND: if (!rx_mr) begin
               state_d = ST_GAP;
               ack     = 1'b1;
            end
            ST_GAP: if (gap_done) begin
               if (!en) state_d = ST_END;
               else if (data_new && rx_mr) begin
                  state_d = ST_SEND;
                  take    = 1'b1;
               end
            end
            ST_END: if (rx_mr) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/mon_tx_slot.sv
`timescale 1ns/1ps
module mon_tx_slot
   import mon_tx_pkg::*;
#(
   parameter int unsigned          DATA_W   = 8,
   parameter logic [DATA_W-1:0]    IDLE_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_byte,
   input  mtx_state_t        state,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_mx
);
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= IDLE_VAL;
      else if (load) hold_q <= load_byte;
   end

   always_comb begin
      tx_mx   = (state != ST_SEND);
      tx_byte = ((state == ST_SEND) || (state == ST_GAP)) ? hold_q : IDLE_VAL;
   end
endmodule

// File: rtl/mon_tx_ctrl.sv
`timescale 1ns/1ps
module mon_tx_ctrl
   import mon_tx_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       ADDR_W     = 2,
   parameter int unsigned       GAP_FRAMES = 1,
   parameter logic [DATA_W-1:0] IDLE_VAL   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              rx_mr,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_mx,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   mtx_state_t        state_w;
   logic              take_w, ack_w, active_w, en_w, new_w;
   logic [DATA_W-1:0] data_w;

   assign active_w = (state_w != ST_IDLE);

   mon_tx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .take(take_w), .ack(ack_w),
      .busy(active_w), .data_q(data_w), .data_new(new_w), .en_q(en_w), .irq(irq)
   );

   mon_tx_fsm #(.GAP_FRAMES(GAP_FRAMES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_mr(rx_mr),
      .en(en_w), .data_new(new_w), .state(state_w), .take(take_w), .ack(ack_w)
   );

   mon_tx_slot #(.DATA_W(DATA_W), .IDLE_VAL(IDLE_VAL)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(take_w), .load_byte(data_w),
      .state(state_w), .tx_byte(tx_byte), .tx_mx(tx_mx)
   );
endmodule

// File: rtl/mon_tx_chk.sv
`timescale 1ns/1ps
module mon_tx_chk #(
   parameter int unsigned       DATA_W   = 8,
   parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb,
   input logic              tx_mx,
   input logic [DATA_W-1:0] tx_byte,
   input logic              irq,
   input logic              active,
   input logic              en
);
   // R2: idle slot content
   p_idle_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (tx_mx && tx_byte == IDLE_VAL));

   // R3: a valid flag never appears without enable
   p_start_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_mx) |-> $past(en));

   // R4: flagged byte implies busy
   p_mx_low_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_mx |-> active);

   // R5: slot changes only at a frame strobe
   p_slot_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> ($stable(tx_mx) && $stable(tx_byte)));

   // R6: interrupt rises together with release of the flag
   p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> tx_mx);
endmodule

bind mon_tx_ctrl mon_tx_chk #(.DATA_W(DATA_W), .IDLE_VAL(IDLE_VAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .tx_mx(tx_mx),
   .tx_byte(tx_byte), .irq(irq), .active(active_w), .en(en_w)
);

// File: tb/mon_tx_ctrl_tb.sv
`timescale 1ns/1ps
module mon_tx_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       rx_mr = 1'b1;
   logic [7:0] tx_byte;
   logic       tx_mx;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   mon_tx_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_mr(rx_mr),
      .tx_byte(tx_byte), .tx_mx(tx_mx), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic frame(input logic mr);
      @(negedge clk);
      rx_mr = mr; frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic slot_is(input string req, input int mx, input int b);
      chk(req, "tx_mx", int'(tx_mx), mx);
      chk(req, "tx_byte", int'(tx_byte), b);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      slot_is("R1", 1, 8'hFF);
      chk("R1", "irq", int'(irq), 0);
      reg_read(2'd2, d);
      chk("R1", "status", int'(d), 0);
   endtask

   task automatic t_no_enable();
      logic [7:0] d;
      reg_write(2'd0, 8'h5A);
      frame(1'b1);
      frame(1'b1);
      slot_is("R2", 1, 8'hFF);
      reg_read(2'd2, d);
      chk("R2", "busy without enable", int'(d[0]), 0);
      reg_read(2'd0, d);
      chk("R10", "data readback", int'(d), 8'h5A);
      reg_read(2'd3, d);
      chk("R10", "unused address", int'(d), 0);
   endtask

   task automatic t_first_byte();
      logic [7:0] d;
      reg_write(2'd0, 8'hA5);
      reg_write(2'd1, 8'h01);
      reg_read(2'd1, d);
      chk("R10", "ctrl readback", int'(d), 1);
      slot_is("R3", 1, 8'hFF);
      frame(1'b1);
      slot_is("R3", 0, 8'hA5);
      reg_read(2'd2, d);
      chk("R4", "busy on first flag", int'(d[0]), 1);
      reg_write(2'd0, 8'h77);
      frame(1'b1);
      frame(1'b1);
      slot_is("R5", 0, 8'hA5);
      chk("R5", "no irq yet", int'(irq), 0);
   endtask

   task automatic t_ack();
      logic [7:0] d;
      frame(1'b0);
      slot_is("R6", 1, 8'hA5);
      chk("R6", "irq", int'(irq), 1);
      reg_read(2'd2, d);
      chk("R8", "status on read", int'(d), 3);
      chk("R8", "irq after read", int'(irq), 0);
      reg_read(2'd2, d);
      chk("R8", "status second read", int'(d), 1);
   endtask

   task automatic t_gap_next();
      frame(1'b0);
      slot_is("R7", 1, 8'hA5);
      frame(1'b1);
      slot_is("R7", 0, 8'h77);
      frame(1'b0);
      chk("R6", "irq second byte", int'(irq), 1);
   endtask

   task automatic t_end();
      logic [7:0] d;
      reg_write(2'd1, 8'h00);
      frame(1'b0);
      slot_is("R9", 1, 8'hFF);
      reg_read(2'd2, d);
      chk("R9", "busy while mr low", int'(d[0]), 1);
      frame(1'b0);
      reg_read(2'd2, d);
      chk("R9", "busy still held", int'(d[0]), 1);
      frame(1'b1);
      reg_read(2'd2, d);
      chk("R9", "busy dropped", int'(d[0]), 0);
      slot_is("R2", 1, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_no_enable();
      t_first_byte();
      t_ack();
      t_gap_next();
      t_end();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule